// File: doc/BRIEF.md
# Deferred USB Function Address Register

This block holds the device address that a USB function answers to. Firmware writes a new address into a byte-wide register and can read it back in the next cycle. The token-matching logic does not see that value yet. It keeps using the active address until the protocol engine signals that the control transfer which assigned the new address has completed its status stage. Only then is the staged value promoted. A status bit in the top position of the register reads as one while a staged value is waiting for promotion.

There are two clearing inputs, one for USB bus reset and one for entry into deep low-power modes. Either one returns the staged address, the active address and the status bit to zero. The active address feeds the token decoder directly as a 7-bit output.

Top module: `fn_addr_defer`

## Requirements
- R1: After the asynchronous reset, the active address is 0, the update-pending status is 0, and a register read returns 8'h00.
- R2: A write (reg_sel and reg_wr high at a clock edge) stores reg_wdata[6:0] as the staged address and sets the pending status. A read in the next cycle returns {1'b1, staged[6:0]}: the status sits in bit 7 and the address in bits 6:0.
- R3: Bit 7 of write data is ignored. Writing with reg_wdata[7] at 0 or at 1 gives the same read-back and the same pending state.
- R4: While no promotion occurs, the active address keeps its previous value, even after new writes.
- R5: A commit pulse in a cycle where an update is pending copies the staged address to the active address at that edge and clears the pending status.
- R6: A commit pulse with no update pending changes neither the active address nor the read-back value.
- R7: A second write before the commit replaces the staged value and leaves the pending status set. The next commit promotes the latest value.
- R8: A write and a commit at the same edge promote the previously staged value. The newly written value stays staged, with pending still set.
- R9: A USB bus reset pulse clears the active address, the staged address and the pending status to zero, and it overrides a write or commit in the same cycle.
- R10: A low-power entry pulse clears the same state as R9, with the same priority.
- R11: reg_rdata is 8'h00 unless reg_sel and reg_rd are both high.
- R12: reg_wr without reg_sel has no effect on the register or the active address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_enter | input | 1 | Pulse on entry to a deep low-power mode; clears all state |
| bus_reset | input | 1 | Pulse on USB bus reset; clears all state |
| reg_sel | input | 1 | Register selected by the register bus |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data; bits 6:0 are the address, bit 7 is ignored |
| reg_rdata | output | 8 | Read data: bit 7 is the pending status, bits 6:0 the staged address |
| commit | input | 1 | Pulse from the protocol engine at the end of the address-setting status stage |
| active_addr | output | 7 | Address currently used for token matching |
| update_pending | output | 1 | High while a staged address awaits promotion |

## Verification
The bench builds the block with its default 7-bit address and 8-bit data word. At that size all 256 write-data values can be swept. Each value is written, read back, checked against an unchanged active address, and then committed. This covers every address pattern and both states of the ignored top bit. Directed sequences then cover the orderings: a double write before a commit, a write and a commit at the same edge, a commit with nothing pending, unselected writes, and both clearing inputs colliding with a write and a commit.

// File: rtl/fn_addr_pkg.sv
package fn_addr_pkg;

    // Per-cycle control decisions handed from the sequencer to the state core.
    typedef struct packed {
        logic clear;    // drop everything back to zero
        logic load;     // capture new staged address
        logic promote;  // move staged address to active
    } fa_ctl_t;

endpackage

// File: rtl/fn_addr_bus_if.sv
module fn_addr_bus_if #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] staged,
    input  logic              pending,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_value,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned PAD_W = DATA_W - ADDR_W - 1;

    logic [DATA_W-1:0] view_d;

    always_comb begin
        wr_strobe = reg_sel & reg_wr;
        // status bit position is never writable; only the address field is taken
        wr_value  = reg_wdata[ADDR_W-1:0];
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb view_d = {pending, {PAD_W{1'b0}}, staged};
        end else begin : g_nopad
            always_comb view_d = {pending, staged};
        end
    endgenerate

    always_comb begin
        reg_rdata = (reg_sel & reg_rd) ? view_d : '0;
    end

endmodule

// File: rtl/fn_addr_seq.sv
module fn_addr_seq
    import fn_addr_pkg::*;
(
    input  logic    lp_enter,
    input  logic    bus_reset,
    input  logic    wr_strobe,
    input  logic    commit,
    input  logic    pending,
    output fa_ctl_t ctl
);
    always_comb begin
        ctl.clear   = lp_enter | bus_reset;
        ctl.load    = wr_strobe & ~ctl.clear;
        ctl.promote = commit & pending & ~ctl.clear;
    end
endmodule

// File: rtl/fn_addr_core.sv
module fn_addr_core
    import fn_addr_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fa_ctl_t           ctl,
    input  logic [ADDR_W-1:0] wr_value,
    output logic [ADDR_W-1:0] staged,
    output logic [ADDR_W-1:0] active,
    output logic              pending
);
    typedef struct packed {
        logic [ADDR_W-1:0] staged;
        logic [ADDR_W-1:0] active;
        logic              pending;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl.clear) begin
            st_d = '0;
        end else begin
            if (ctl.promote) begin
                st_d.active  = st_q.staged;
                st_d.pending = 1'b0;
            end
            if (ctl.load) begin
                st_d.staged  = wr_value;
                st_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        staged  = st_q.staged;
        active  = st_q.active;
        pending = st_q.pending;
    end

    a_r2_load_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.load |=> pending);
    a_r7_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.load |=> staged == $past(wr_value));
    a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.promote && !ctl.clear) |=> $stable(active));
    a_r5_promote_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.promote |=> active == $past(staged));
    a_r5_promote_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.promote && !ctl.load) |=> !pending);
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clear |=> (active == '0 && staged == '0 && !pending));

endmodule

// File: rtl/fn_addr_defer.sv
module fn_addr_defer
    import fn_addr_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_enter,
    input  logic              bus_reset,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              commit,
    output logic [ADDR_W-1:0] active_addr,
    output logic              update_pending
);
    fa_ctl_t           ctl;
    logic              wr_strobe;
    logic [ADDR_W-1:0] wr_value;
    logic [ADDR_W-1:0] staged;
    logic              pending;

    fn_addr_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .staged    (staged),
        .pending   (pending),
        .wr_strobe (wr_strobe),
        .wr_value  (wr_value),
        .reg_rdata (reg_rdata)
    );

    fn_addr_seq u_seq (
        .lp_enter  (lp_enter),
        .bus_reset (bus_reset),
        .wr_strobe (wr_strobe),
        .commit    (commit),
        .pending   (pending),
        .ctl       (ctl)
    );

    fn_addr_core #(.ADDR_W(ADDR_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .wr_value (wr_value),
        .staged   (staged),
        .active   (active_addr),
        .pending  (pending)
    );

    assign update_pending = pending;

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_rd) |-> reg_rdata == '0);
    a_r12_unselected_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel && !commit && !lp_enter && !bus_reset) |=> $stable(update_pending) && $stable(active_addr));

endmodule

// File: tb/fn_addr_defer_bench.sv
module fn_addr_defer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_enter = 1'b0, bus_reset = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, commit = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] active_addr;
    logic       update_pending;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    fn_addr_defer u_fn_addr_defer (
        .clk(clk), .rst_n(rst_n), .lp_enter(lp_enter), .bus_reset(bus_reset),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .commit(commit), .active_addr(active_addr),
        .update_pending(update_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock with the given strobes; returns at the following negedge
    task automatic step(input bit sel, input bit wr, input logic [7:0] wd,
                        input bit cm, input bit br, input bit lp);
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        commit = cm; bus_reset = br; lp_enter = lp;
        @(posedge clk);
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; commit = 0; bus_reset = 0; lp_enter = 0;
    endtask

    task automatic rd(output logic [7:0] v);
        reg_sel = 1; reg_rd = 1;
        #1;
        v = reg_rdata;
        reg_sel = 0; reg_rd = 0;
        #1;
    endtask

    logic [7:0] r;
    logic [6:0] prev_active;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 active_before_release", active_addr, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 active", active_addr, 0);
        chk("R1 pending", update_pending, 0);
        rd(r); chk("R1 rdata", r, 8'h00);

        // exhaustive sweep of write data (R2, R3, R4, R5)
        prev_active = 0;
        for (int v = 0; v < 256; v++) begin
            step(1, 1, v[7:0], 0, 0, 0);
            rd(r);
            chk("R2 readback", r, {1'b1, v[6:0]});
            chk("R3 pending", update_pending, 1);
            chk("R4 active_held", active_addr, prev_active);
            step(0, 0, 8'h00, 1, 0, 0);
            chk("R5 active_promoted", active_addr, v[6:0]);
            chk("R5 pending_cleared", update_pending, 0);
            rd(r);
            chk("R5 readback_after", r, {1'b0, v[6:0]});
            prev_active = v[6:0];
        end

        // R11: no read strobe, or not selected
        reg_rd = 1; #1; chk("R11 rd_no_sel", reg_rdata, 0); reg_rd = 0;
        reg_sel = 1; #1; chk("R11 sel_no_rd", reg_rdata, 0); reg_sel = 0; #1;

        // R6: commit with nothing pending
        step(0, 0, 8'h00, 1, 0, 0);
        chk("R6 active", active_addr, 7'h7F);
        rd(r); chk("R6 readback", r, 8'h7F);

        // R12: unselected write
        step(0, 1, 8'h15, 0, 0, 0);
        rd(r); chk("R12 readback", r, 8'h7F);
        chk("R12 pending", update_pending, 0);
        step(0, 0, 8'h00, 1, 0, 0);
        chk("R12 active", active_addr, 7'h7F);

        // R7: double write then commit
        step(1, 1, 8'h11, 0, 0, 0);
        step(1, 1, 8'h22, 0, 0, 0);
        rd(r); chk("R7 readback", r, 8'hA2);
        chk("R7 active_held", active_addr, 7'h7F);
        step(0, 0, 8'h00, 1, 0, 0);
        chk("R7 active", active_addr, 7'h22);

        // R8: write and commit at the same edge
        step(1, 1, 8'h33, 0, 0, 0);
        step(1, 1, 8'h44, 1, 0, 0);
        chk("R8 active_old_staged", active_addr, 7'h33);
        chk("R8 still_pending", update_pending, 1);
        rd(r); chk("R8 readback", r, 8'hC4);
        step(0, 0, 8'h00, 1, 0, 0);
        chk("R8 active_new", active_addr, 7'h44);

        // R9: bus reset, also colliding with write and commit
        step(1, 1, 8'h55, 0, 0, 0);
        step(1, 1, 8'h66, 1, 1, 0);
        chk("R9 active", active_addr, 0);
        chk("R9 pending", update_pending, 0);
        rd(r); chk("R9 readback", r, 8'h00);

        // R10: low-power entry, same collision
        step(1, 1, 8'h2A, 0, 0, 0);
        step(0, 0, 8'h00, 1, 0, 0);
        step(1, 1, 8'h3B, 0, 0, 0);
        chk("R10 setup_active", active_addr, 7'h2A);
        step(1, 1, 8'h4C, 1, 0, 1);
        chk("R10 active", active_addr, 0);
        chk("R10 pending", update_pending, 0);
        rd(r); chk("R10 readback", r, 8'h00);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule